// File: doc/BRIEF.md
# Clock Output Stop and Strap Controller

This block sits between the free-running clock sources of a system clock generator and its output pads. It gates every clock output (four CPU clocks, twelve SDRAM clocks, six stoppable PCI clocks plus one free-running PCI clock, two reference clocks, an IOAPIC reference, a 48 MHz clock and a 24 MHz clock). The gating follows two active-low stop requests and a per-output enable bit supplied by a register file. Every gate opens and closes only while its own source clock is low, so no output ever shows a shortened pulse.

After reset a small state machine in the reference-clock domain holds the shared strap pins as inputs for a fixed sampling window. It then captures four frequency-select straps and a mode strap, and releases those pins to drive clocks. The captured mode decides the role of two shared pins. With mode 1 they drive the PCI5 and REF1 clocks. With mode 0 they are inputs: the pin in the PCI5 position carries the PCI stop request and the pin in the REF1 position carries the CPU stop request. The block also selects the effective frequency-select code and returns the captured straps for readback.

The state machine has three states. SAMPLE counts the window and leaves for LATCH on its last cycle. LATCH captures the straps for one cycle and moves to RUN. RUN is final until the next reset.

Top module: `clk_stop_strap_ctrl`

## Requirements
- R1: The straps are captured once, in LATCH. Pin changes after that have no effect on `strap_rb` or `mode_q`, and `strap_rb[3:0]` holds the captured frequency-select straps in pin order 3..0.
- R2: Until RUN is reached, `strap_rb` reads 4'b1111, `strap_done`, `strap_oe` and `shr_oe` are 0, and every gated clock output is low.
- R3: With mode 1 captured, `shr_oe` is 2'b11, `pci_clk[5]` and `ref_clk[1]` run, and both stop pins are ignored. With mode 0 captured, `shr_oe` is 2'b00 and those two clocks are held low. `shr_oe[0]` is the PCI5/PCI-stop pin and `shr_oe[1]` is the REF1/CPU-stop pin.
- R4: With mode 0, a low level on `shr_cpu_stop_pin`, passed through a two-flop synchronizer, holds all four CPU clocks low while the other clocks keep running.
- R5: With mode 0, a low level on `shr_pci_stop_pin` holds `pci_clk[5:0]` low while `pcif_clk` keeps running.
- R6: An output whose enable bit is 0 is held low, and its neighbours are unaffected.
- R7: `fs_code` equals `cfg_fs` when `cfg_fs_sel` is 1 and equals `strap_rb` when `cfg_fs_sel` is 0.
- R8: When `cfg_tristate` is 1, `clk_oe`, `strap_oe` and `shr_oe` are all 0. When it is 0 and the block is in RUN, `clk_oe` and `strap_oe` are 1.
- R9: Every high pulse on a gated output is as wide as the high phase of its source clock, so no runt pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; domain of the state machine and sources REF/IOAPIC |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| src_cpu | input | 1 | CPU clock source |
| src_sdram | input | 1 | SDRAM clock source |
| src_pci | input | 1 | PCI clock source |
| src_usb | input | 1 | 48 MHz source |
| src_sio | input | 1 | 24 MHz source |
| strap_fs_pin | input | 4 | Pad input value of the frequency-select strap pins |
| strap_mode_pin | input | 1 | Pad input value of the mode strap pin |
| shr_pci_stop_pin | input | 1 | Pad input of the PCI5 / PCI-stop shared pin |
| shr_cpu_stop_pin | input | 1 | Pad input of the REF1 / CPU-stop shared pin |
| en_cpu | input | 4 | Per-output enables, CPU clocks |
| en_sdram | input | 12 | Per-output enables, SDRAM clocks |
| en_pci | input | 6 | Per-output enables, stoppable PCI clocks |
| en_pcif | input | 1 | Enable, free-running PCI clock |
| en_ref | input | 2 | Enables, reference clocks |
| en_ioapic | input | 1 | Enable, IOAPIC clock |
| en_usb | input | 1 | Enable, 48 MHz clock |
| en_sio | input | 1 | Enable, 24 MHz clock |
| cfg_fs_sel | input | 1 | 1: frequency code from register, 0: from straps |
| cfg_fs | input | 4 | Register frequency-select code |
| cfg_tristate | input | 1 | 1: all clock outputs high impedance |
| cpu_clk | output | 4 | Gated CPU clocks |
| sdram_clk | output | 12 | Gated SDRAM clocks |
| pci_clk | output | 6 | Gated stoppable PCI clocks |
| pcif_clk | output | 1 | Gated free-running PCI clock |
| ref_clk | output | 2 | Gated reference clocks |
| ioapic_clk | output | 1 | Gated IOAPIC clock |
| usb_clk | output | 1 | Gated 48 MHz clock |
| sio_clk | output | 1 | Gated 24 MHz clock |
| clk_oe | output | 1 | Pad output enable for all clock outputs |
| strap_oe | output | 1 | Pad output enable for the strap/clock shared pins |
| shr_oe | output | 2 | Pad output enables of the two mode-dependent pins |
| fs_code | output | 4 | Effective frequency-select code |
| strap_rb | output | 4 | Captured frequency-select straps |
| mode_q | output | 1 | Captured mode strap |
| strap_done | output | 1 | High once RUN is reached |

## Verification
The assertions assume that the strap pins are steady through the LATCH cycle. They also assume that a stop request is held for at least two reference cycles, because shorter pulses may be lost in the synchronizer. They further assume that the enable and stop inputs change slowly compared with the slowest source clock. The bench drives every such input well away from reset release and then waits many source cycles before it counts output edges. The stop pins are only toggled in RUN, and the straps are only changed after capture.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_LATCH  = 2'd1,
        ST_RUN    = 2'd2
    } strap_st_e;
endpackage

// File: rtl/strap_fsm.sv
module strap_fsm
    import clkctl_pkg::*;
#(
    parameter int SAMPLE_CYC = 16,
    parameter int FS_W       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] fs_pin,
    input  logic            mode_pin,
    input  logic            tristate,
    output logic            done,
    output logic [FS_W-1:0] fs_q,
    output logic            mode_q,
    output logic            strap_oe,
    output logic [1:0]      shr_oe
);
    localparam int CW = (SAMPLE_CYC > 2) ? $clog2(SAMPLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_CYC - 1);

    strap_st_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_SAMPLE;
            cnt_q  <= '0;
            fs_q   <= '1;
            mode_q <= 1'b1;
        end else begin
            st_q <= st_d;
            if (st_q == ST_SAMPLE) cnt_q <= cnt_q + 1'b1;
            if (st_q == ST_LATCH) begin
                fs_q   <= fs_pin;
                mode_q <= mode_pin;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SAMPLE: if (cnt_q == LAST) st_d = ST_LATCH;
            ST_LATCH:  st_d = ST_RUN;
            ST_RUN:    st_d = ST_RUN;
            default:   st_d = ST_SAMPLE;
        endcase
    end

    always_comb begin
        done     = 1'b0;
        strap_oe = 1'b0;
        shr_oe   = 2'b00;
        unique case (st_q)
            ST_SAMPLE, ST_LATCH: ;
            ST_RUN: begin
                done     = 1'b1;
                strap_oe = ~tristate;
                shr_oe   = {2{mode_q & ~tristate}};
            end
            default: ;
        endcase
    end

    assert_oe_off_before_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |-> (!strap_oe && shr_oe == 2'b00));

    assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> ($stable(fs_q) && $stable(mode_q)));
endmodule

// File: rtl/stop_sync.sv
module stop_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] s1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '1;
            q    <= '1;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_sync_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 2) && !$past(d[i]) && !$past(d[i], 2)) |-> !q[i]);
    end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int N = 4
) (
    input  logic         src_clk,
    input  logic         rst_n,
    input  logic [N-1:0] en,
    output logic [N-1:0] clk_out
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic s1_q, s2_q, gate_q;

        always_ff @(posedge src_clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= en[i];
                s2_q <= s1_q;
            end
        end

        always_ff @(negedge src_clk or negedge rst_n) begin
            if (!rst_n) gate_q <= 1'b0;
            else        gate_q <= s2_q;
        end

        assign clk_out[i] = src_clk & gate_q;
    end
endmodule

// File: rtl/clk_stop_strap_ctrl.sv
module clk_stop_strap_ctrl #(
    parameter int SAMPLE_CYC = 16,
    parameter int FS_W       = 4,
    parameter int N_CPU      = 4,
    parameter int N_SDRAM    = 12,
    parameter int N_PCI      = 6
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               src_cpu,
    input  logic               src_sdram,
    input  logic               src_pci,
    input  logic               src_usb,
    input  logic               src_sio,
    input  logic [FS_W-1:0]    strap_fs_pin,
    input  logic               strap_mode_pin,
    input  logic               shr_pci_stop_pin,
    input  logic               shr_cpu_stop_pin,
    input  logic [N_CPU-1:0]   en_cpu,
    input  logic [N_SDRAM-1:0] en_sdram,
    input  logic [N_PCI-1:0]   en_pci,
    input  logic               en_pcif,
    input  logic [1:0]         en_ref,
    input  logic               en_ioapic,
    input  logic               en_usb,
    input  logic               en_sio,
    input  logic               cfg_fs_sel,
    input  logic [FS_W-1:0]    cfg_fs,
    input  logic               cfg_tristate,
    output logic [N_CPU-1:0]   cpu_clk,
    output logic [N_SDRAM-1:0] sdram_clk,
    output logic [N_PCI-1:0]   pci_clk,
    output logic               pcif_clk,
    output logic [1:0]         ref_clk,
    output logic               ioapic_clk,
    output logic               usb_clk,
    output logic               sio_clk,
    output logic               clk_oe,
    output logic               strap_oe,
    output logic [1:0]         shr_oe,
    output logic [FS_W-1:0]    fs_code,
    output logic [FS_W-1:0]    strap_rb,
    output logic               mode_q,
    output logic               strap_done
);
    localparam int N_PCI_ALL = N_PCI + 1;
    localparam int N_REF_ALL = 3;

    logic [1:0] stop_s;   // [0] PCI stop, [1] CPU stop, active low
    logic       cpu_halt, pci_halt;

    logic [N_CPU-1:0]     en_cpu_d,   en_cpu_q;
    logic [N_SDRAM-1:0]   en_sdram_d, en_sdram_q;
    logic [N_PCI_ALL-1:0] en_pci_d,   en_pci_q;
    logic [N_REF_ALL-1:0] en_ref_d,   en_ref_q;
    logic [1:0]           en_per_d,   en_per_q;
    logic [N_PCI_ALL-1:0] pci_all;
    logic [N_REF_ALL-1:0] ref_all;

    strap_fsm #(.SAMPLE_CYC(SAMPLE_CYC), .FS_W(FS_W)) u_fsm (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .fs_pin   (strap_fs_pin),
        .mode_pin (strap_mode_pin),
        .tristate (cfg_tristate),
        .done     (strap_done),
        .fs_q     (strap_rb),
        .mode_q   (mode_q),
        .strap_oe (strap_oe),
        .shr_oe   (shr_oe)
    );

    stop_sync #(.N(2)) u_stop (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     ({shr_cpu_stop_pin, shr_pci_stop_pin}),
        .q     (stop_s)
    );

    assign cpu_halt = ~mode_q & ~stop_s[1];
    assign pci_halt = ~mode_q & ~stop_s[0];
    assign fs_code  = cfg_fs_sel ? cfg_fs : strap_rb;
    assign clk_oe   = ~cfg_tristate;

    always_comb begin
        en_cpu_d   = {N_CPU{strap_done & ~cpu_halt}} & en_cpu;
        en_sdram_d = {N_SDRAM{strap_done}} & en_sdram;
        en_pci_d   = {strap_done & en_pcif,
                      {N_PCI{strap_done & ~pci_halt}} & en_pci & {mode_q, {(N_PCI-1){1'b1}}}};
        en_ref_d   = {strap_done & en_ioapic,
                      strap_done & en_ref[1] & mode_q,
                      strap_done & en_ref[0]};
        en_per_d   = {strap_done & en_sio, strap_done & en_usb};
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            en_cpu_q   <= '0;
            en_sdram_q <= '0;
            en_pci_q   <= '0;
            en_ref_q   <= '0;
            en_per_q   <= '0;
        end else begin
            en_cpu_q   <= en_cpu_d;
            en_sdram_q <= en_sdram_d;
            en_pci_q   <= en_pci_d;
            en_ref_q   <= en_ref_d;
            en_per_q   <= en_per_d;
        end
    end

    clk_gate_bank #(.N(N_CPU)) u_g_cpu (
        .src_clk(src_cpu), .rst_n(rst_n), .en(en_cpu_q), .clk_out(cpu_clk));
    clk_gate_bank #(.N(N_SDRAM)) u_g_sdram (
        .src_clk(src_sdram), .rst_n(rst_n), .en(en_sdram_q), .clk_out(sdram_clk));
    clk_gate_bank #(.N(N_PCI_ALL)) u_g_pci (
        .src_clk(src_pci), .rst_n(rst_n), .en(en_pci_q), .clk_out(pci_all));
    clk_gate_bank #(.N(N_REF_ALL)) u_g_ref (
        .src_clk(clk_ref), .rst_n(rst_n), .en(en_ref_q), .clk_out(ref_all));
    clk_gate_bank #(.N(1)) u_g_usb (
        .src_clk(src_usb), .rst_n(rst_n), .en(en_per_q[0]), .clk_out(usb_clk));
    clk_gate_bank #(.N(1)) u_g_sio (
        .src_clk(src_sio), .rst_n(rst_n), .en(en_per_q[1]), .clk_out(sio_clk));

    assign pci_clk    = pci_all[N_PCI-1:0];
    assign pcif_clk   = pci_all[N_PCI];
    assign ref_clk    = ref_all[1:0];
    assign ioapic_clk = ref_all[2];

    assert_cpu_stop_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strap_done && !mode_q && !stop_s[1]) |=> (en_cpu_q == '0));

    assert_pcif_free_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strap_done && en_pcif) |=> en_pci_q[N_PCI]);

    assert_mode1_stops_ignored_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strap_done && mode_q) |=> (en_cpu_q == $past(en_cpu)));
endmodule

// File: tb/test_clk_stop_strap_ctrl.sv
module test_clk_stop_strap_ctrl;
    logic clk_ref = 0, src_cpu = 0, src_sdram = 0, src_pci = 0, src_usb = 0, src_sio = 0;
    logic rst_n;
    logic [3:0] strap_fs_pin;
    logic strap_mode_pin, shr_pci_stop_pin, shr_cpu_stop_pin;
    logic [3:0] en_cpu; logic [11:0] en_sdram; logic [5:0] en_pci;
    logic en_pcif, en_ioapic, en_usb, en_sio; logic [1:0] en_ref;
    logic cfg_fs_sel, cfg_tristate; logic [3:0] cfg_fs;
    logic [3:0] cpu_clk; logic [11:0] sdram_clk; logic [5:0] pci_clk;
    logic pcif_clk, ioapic_clk, usb_clk, sio_clk, clk_oe, strap_oe, mode_q, strap_done;
    logic [1:0] ref_clk, shr_oe; logic [3:0] fs_code, strap_rb;

    always #2 clk_ref   = ~clk_ref;   // 250 MHz
    always #3 src_cpu   = ~src_cpu;
    always #3 src_sdram = ~src_sdram;
    always #6 src_pci   = ~src_pci;
    always #4 src_usb   = ~src_usb;
    always #8 src_sio   = ~src_sio;

    clk_stop_strap_ctrl i_clk_stop_strap_ctrl (.*);

    int pass_cnt = 0, fail_cnt = 0;
    int c_cpu0 = 0, c_pci0 = 0, c_pci5 = 0, c_pcif = 0, c_sd2 = 0, c_sd3 = 0,
        c_ref1 = 0, c_usb = 0, c_sio = 0, c_io = 0;
    int d[10];
    int runt_cpu = 0, runt_pci = 0;
    realtime t_cpu = 0, t_pci = 0;

    always @(posedge cpu_clk[0])   begin c_cpu0++; t_cpu = $realtime; end
    always @(negedge cpu_clk[0])   if ($realtime - t_cpu < 2.5) runt_cpu++;
    always @(posedge pci_clk[0])   begin c_pci0++; t_pci = $realtime; end
    always @(negedge pci_clk[0])   if ($realtime - t_pci < 5.5) runt_pci++;
    always @(posedge pci_clk[5])   c_pci5++;
    always @(posedge pcif_clk)     c_pcif++;
    always @(posedge sdram_clk[2]) c_sd2++;
    always @(posedge sdram_clk[3]) c_sd3++;
    always @(posedge ref_clk[1])   c_ref1++;
    always @(posedge usb_clk)      c_usb++;
    always @(posedge sio_clk)      c_sio++;
    always @(posedge ioapic_clk)   c_io++;

    // vector: [12] cpu stop pin, [11] pci stop pin, [10] fs_sel, [9:6] cfg_fs,
    //         [5] cpu expected running, [4] pci expected running, [3:0] expected fs_code
    localparam logic [12:0] VEC [5] = '{
        {1'b1, 1'b1, 1'b0, 4'b0011, 1'b1, 1'b1, 4'b1010},
        {1'b0, 1'b1, 1'b1, 4'b0011, 1'b0, 1'b1, 4'b0011},
        {1'b1, 1'b0, 1'b1, 4'b1100, 1'b1, 1'b0, 4'b1100},
        {1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b1010},
        {1'b1, 1'b1, 1'b1, 4'b1111, 1'b1, 1'b1, 4'b1111}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic window();
        int s[10];
        s = '{c_cpu0, c_pci0, c_pci5, c_pcif, c_sd2, c_sd3, c_ref1, c_usb, c_sio, c_io};
        #200;
        d[0] = c_cpu0 - s[0]; d[1] = c_pci0 - s[1]; d[2] = c_pci5 - s[2];
        d[3] = c_pcif - s[3]; d[4] = c_sd2 - s[4]; d[5] = c_sd3 - s[5];
        d[6] = c_ref1 - s[6]; d[7] = c_usb - s[7]; d[8] = c_sio - s[8]; d[9] = c_io - s[9];
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fail_cnt++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 0; strap_fs_pin = 4'b1010; strap_mode_pin = 0;
        shr_pci_stop_pin = 1; shr_cpu_stop_pin = 1;
        en_cpu = '1; en_sdram = '1; en_pci = '1; en_pcif = 1; en_ref = '1;
        en_ioapic = 1; en_usb = 1; en_sio = 1;
        cfg_fs_sel = 0; cfg_fs = 4'b0000; cfg_tristate = 0;
        #21;
        chk(strap_rb == 4'b1111, "R2 strap_rb in reset", strap_rb, 15);
        rst_n = 1;
        #21;
        chk(!strap_done, "R2 done in window", strap_done, 0);
        chk(!strap_oe && shr_oe == 2'b00, "R2 pad enables in window", {strap_oe, shr_oe}, 0);
        chk(cpu_clk == 0 && sdram_clk == 0, "R2 clocks low in window", cpu_clk, 0);
        #200;
        strap_fs_pin = 4'b0101; strap_mode_pin = 1;   // must be ignored
        #100;
        chk(strap_done, "R1 done", strap_done, 1);
        chk(strap_rb == 4'b1010, "R1 latched straps hold", strap_rb, 10);
        chk(!mode_q, "R1 latched mode holds", mode_q, 0);
        chk(shr_oe == 2'b00, "R3 mode0 shr_oe", shr_oe, 0);
        chk(fs_code == 4'b1010, "R7 fs_code from straps", fs_code, 10);
        chk(strap_oe && clk_oe, "R8 enables in run", {strap_oe, clk_oe}, 3);
        window();
        chk(d[2] == 0, "R3 pci5 low in mode0", d[2], 0);
        chk(d[6] == 0, "R3 ref1 low in mode0", d[6], 0);
        chk(d[9] > 0, "R3 ioapic runs", d[9], 1);

        for (int v = 0; v < 5; v++) begin
            shr_cpu_stop_pin = VEC[v][12]; shr_pci_stop_pin = VEC[v][11];
            cfg_fs_sel = VEC[v][10]; cfg_fs = VEC[v][9:6];
            #150;
            window();
            chk((d[0] > 0) == VEC[v][5], $sformatf("R4 cpu0 vec%0d", v), d[0], VEC[v][5]);
            chk((d[1] > 0) == VEC[v][4], $sformatf("R5 pci0 vec%0d", v), d[1], VEC[v][4]);
            chk(d[3] > 0, $sformatf("R5 pcif free vec%0d", v), d[3], 1);
            chk(d[4] > 0 && d[7] > 0, $sformatf("R4 others run vec%0d", v), d[4], 1);
            chk(fs_code == VEC[v][3:0], $sformatf("R7 fs_code vec%0d", v), fs_code, VEC[v][3:0]);
        end

        en_sdram[3] = 0; en_usb = 0;
        #150;
        window();
        chk(d[5] == 0, "R6 sdram3 disabled", d[5], 0);
        chk(d[4] > 0, "R6 sdram2 neighbour runs", d[4], 1);
        chk(d[7] == 0, "R6 usb disabled", d[7], 0);
        chk(d[8] > 0, "R6 sio runs", d[8], 1);
        en_sdram[3] = 1; en_usb = 1;

        cfg_tristate = 1;
        #10;
        chk(!clk_oe && !strap_oe && shr_oe == 2'b00, "R8 tristate", {clk_oe, strap_oe, shr_oe}, 0);
        cfg_tristate = 0;
        #10;
        chk(clk_oe && strap_oe, "R8 tristate released", {clk_oe, strap_oe}, 3);

        chk(runt_cpu == 0, "R9 cpu runt pulses", runt_cpu, 0);
        chk(runt_pci == 0, "R9 pci runt pulses", runt_pci, 0);

        rst_n = 0; strap_fs_pin = 4'b0110; strap_mode_pin = 1;
        shr_pci_stop_pin = 0; shr_cpu_stop_pin = 0; cfg_fs_sel = 0;
        #20; rst_n = 1;
        #300;
        chk(mode_q && shr_oe == 2'b11, "R3 mode1 shr_oe", shr_oe, 3);
        chk(strap_rb == 4'b0110, "R1 second capture", strap_rb, 6);
        window();
        chk(d[0] > 0, "R3 cpu ignores stop pin in mode1", d[0], 1);
        chk(d[1] > 0 && d[2] > 0, "R3 pci0/pci5 run in mode1", d[2], 1);
        chk(d[6] > 0, "R3 ref1 runs in mode1", d[6], 1);
        summary();
    end
endmodule